// File: doc/BRIEF.md
# Software-Refilled Translation Buffer

This block turns 32-bit virtual addresses into physical addresses for both instruction fetches and data accesses. Pages are 4 KB. The low 12 bits of an address are the page offset and pass through unchanged. The upper 20 bits are the virtual page number (VPN). The block compares the VPN against every stored entry in the same cycle. On a hit it returns the stored physical page number (PPN) with the offset appended. The result is combinational, so it is valid in the same cycle as the request.

The block never walks the page table itself. On a miss it records the failing VPN in a miss register and raises a trap request to the processor. It also presents a ready-made page-table-entry address: a software-loaded base register plus the VPN times four, since each table entry is four bytes. The software handler reads that entry and refills one slot through a write port. That write also drops the trap.

The instruction port and the data port share one lookup. When both request in the same cycle, the data request is served and the instruction port is told to stall.

Top module: `sw_tlb`

## Requirements
- R1: On a hit, `respPaddr` is the matching entry's 20-bit PPN in bits 31:12, followed by bits 11:0 of the served virtual address.
- R2: Any of the 16 slots can supply a hit, because the VPN (bits 31:12 of the address) is compared against all valid slots in the same cycle.
- R3: After reset, no slot is valid, so every lookup misses. After reset, `trapReq` is 0 and `missVpn` is 0.
- R4: When `instReq` and `dataReq` are both high, the data address is served, `respIsData` is 1 and `instStall` is 1. When only `instReq` is high, `instStall` is 0.
- R5: A lookup that misses while no trap is pending and no refill is being written does three things on the next clock edge. It sets `trapReq`, stores the VPN in `missVpn`, and sets `missIsData` to 1 for a data access or 0 for an instruction access.
- R6: While `trapReq` is high, further misses leave `missVpn` and `missIsData` unchanged and keep `trapReq` high.
- R7: When `refillWe` is high, slot `refillIdx` is written with `refillVpn` and `refillPpn` and marked valid at the next edge, and `trapReq` clears at that edge. A miss in the same cycle as the write is not captured.
- R8: `pteAddr` equals the page-table base plus `missVpn` × 4, modulo 2^32. The base is loaded from `ptBaseData` when `ptBaseWe` is high, and resets to 0.
- R9: When several valid slots hold the same VPN, the slot with the lowest index supplies the PPN.
- R10: A hit while a trap is pending returns the correct translation and changes neither `trapReq` nor `missVpn`.
- R11: With neither request high, `respValid` and `respHit` are 0 and no trap is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instReq | input | 1 | Instruction lookup request |
| instVaddr | input | 32 | Instruction virtual address |
| dataReq | input | 1 | Data lookup request |
| dataVaddr | input | 32 | Data virtual address |
| instStall | output | 1 | Instruction request was not served this cycle |
| respValid | output | 1 | A lookup is being served |
| respIsData | output | 1 | The served lookup is from the data port |
| respHit | output | 1 | The served lookup hit |
| respPaddr | output | 32 | Physical address on a hit, 0 otherwise |
| trapReq | output | 1 | Miss trap pending |
| missVpn | output | 20 | Captured VPN of the miss |
| missIsData | output | 1 | The captured miss came from the data port |
| pteAddr | output | 32 | Address of the page-table entry for `missVpn` |
| ptBaseWe | input | 1 | Load the page-table base register |
| ptBaseData | input | 32 | New page-table base value |
| refillWe | input | 1 | Write one slot |
| refillIdx | input | 4 | Slot to write |
| refillVpn | input | 20 | VPN tag to store |
| refillPpn | input | 20 | PPN to store |

## Verification
Every slot is loaded with a distinct mapping. Each slot is then looked up from both ports with offsets 0x000, 0x001, 0x7FF and 0xFFF. This separates a wrong tag compare, a wrong slot select and a truncated or shifted offset.

Simultaneous requests with different hitting pages show whether the right port won. Duplicate tags placed above and below an existing slot show whether the priority runs in the right direction. Two sequences tell apart a miss register that is overwritten from one that holds: misses while a trap is pending, and a miss in the same cycle as a refill.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W       = 32;
  localparam int OFF_W      = 12;
  localparam int PA_W       = 32;
  localparam int VPN_W      = VA_W - OFF_W;
  localparam int PPN_W      = PA_W - OFF_W;
  localparam int PTE_SHIFT  = 2;

  typedef struct packed {
    logic lookValid;
    logic selData;
    logic instStall;
    logic captureMiss;
    logic clearTrap;
  } tlbStrobe_t;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]            validVec,
  input  logic [ENTRIES-1:0][VPN_W-1:0] tagVec,
  input  logic [VPN_W-1:0]              keyVpn,
  output logic                          anyMatch,
  output logic [IDX_W-1:0]              matchIdx
);
  logic [ENTRIES-1:0] matchVec;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign matchVec[g] = validVec[g] && (tagVec[g] == keyVpn);
  end

  always_comb begin
    matchIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i]) matchIdx = IDX_W'(i);
    end
  end

  assign anyMatch = |matchVec;
endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       instReq,
  input  logic       dataReq,
  input  logic       lookHit,
  input  logic       refillWe,
  output tlbStrobe_t strb,
  output logic       trapQ
);
  always_comb begin
    strb.lookValid   = instReq | dataReq;
    strb.selData     = dataReq;
    strb.instStall   = instReq & dataReq;
    strb.clearTrap   = refillWe;
    strb.captureMiss = strb.lookValid & ~lookHit & ~trapQ & ~refillWe;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 trapQ <= 1'b0;
    else if (strb.clearTrap)   trapQ <= 1'b0;
    else if (strb.captureMiss) trapQ <= 1'b1;
  end
endmodule

// File: rtl/tlb_dp.sv
module tlb_dp
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  tlbStrobe_t       strb,
  input  logic [VA_W-1:0]  instVaddr,
  input  logic [VA_W-1:0]  dataVaddr,
  input  logic             ptBaseWe,
  input  logic [PA_W-1:0]  ptBaseData,
  input  logic             refillWe,
  input  logic [IDX_W-1:0] refillIdx,
  input  logic [VPN_W-1:0] refillVpn,
  input  logic [PPN_W-1:0] refillPpn,
  output logic             lookHit,
  output logic [PA_W-1:0]  respPaddr,
  output logic [VPN_W-1:0] missVpn,
  output logic             missIsData,
  output logic [PA_W-1:0]  pteAddr
);
  logic [ENTRIES-1:0]            validQ;
  logic [ENTRIES-1:0][VPN_W-1:0] tagQ;
  logic [ENTRIES-1:0][PPN_W-1:0] ppnQ;
  logic [PA_W-1:0]               ptBaseQ;
  logic [VA_W-1:0]               selVaddr;
  logic                          anyMatch;
  logic [IDX_W-1:0]              matchIdx;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        validQ[g] <= 1'b0;
        tagQ[g]   <= '0;
        ppnQ[g]   <= '0;
      end else if (refillWe && refillIdx == IDX_W'(g)) begin
        validQ[g] <= 1'b1;
        tagQ[g]   <= refillVpn;
        ppnQ[g]   <= refillPpn;
      end
    end
  end

  assign selVaddr = strb.selData ? dataVaddr : instVaddr;

  tlb_cam #(.ENTRIES(ENTRIES)) u_cam (
    .validVec (validQ),
    .tagVec   (tagQ),
    .keyVpn   (selVaddr[VA_W-1:OFF_W]),
    .anyMatch (anyMatch),
    .matchIdx (matchIdx)
  );

  assign lookHit   = strb.lookValid & anyMatch;
  assign respPaddr = lookHit ? {ppnQ[matchIdx], selVaddr[OFF_W-1:0]} : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      missVpn    <= '0;
      missIsData <= 1'b0;
      ptBaseQ    <= '0;
    end else begin
      if (strb.captureMiss) begin
        missVpn    <= selVaddr[VA_W-1:OFF_W];
        missIsData <= strb.selData;
      end
      if (ptBaseWe) ptBaseQ <= ptBaseData;
    end
  end

  assign pteAddr = ptBaseQ +
    {{(PA_W-VPN_W-PTE_SHIFT){1'b0}}, missVpn, {PTE_SHIFT{1'b0}}};
endmodule

// File: rtl/sw_tlb.sv
module sw_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             instReq,
  input  logic [VA_W-1:0]  instVaddr,
  input  logic             dataReq,
  input  logic [VA_W-1:0]  dataVaddr,
  output logic             instStall,
  output logic             respValid,
  output logic             respIsData,
  output logic             respHit,
  output logic [PA_W-1:0]  respPaddr,
  output logic             trapReq,
  output logic [VPN_W-1:0] missVpn,
  output logic             missIsData,
  output logic [PA_W-1:0]  pteAddr,
  input  logic             ptBaseWe,
  input  logic [PA_W-1:0]  ptBaseData,
  input  logic             refillWe,
  input  logic [IDX_W-1:0] refillIdx,
  input  logic [VPN_W-1:0] refillVpn,
  input  logic [PPN_W-1:0] refillPpn
);
  tlbStrobe_t strb;
  logic       lookHit;

  tlb_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .instReq  (instReq),
    .dataReq  (dataReq),
    .lookHit  (lookHit),
    .refillWe (refillWe),
    .strb     (strb),
    .trapQ    (trapReq)
  );

  tlb_dp #(.ENTRIES(ENTRIES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .instVaddr  (instVaddr),
    .dataVaddr  (dataVaddr),
    .ptBaseWe   (ptBaseWe),
    .ptBaseData (ptBaseData),
    .refillWe   (refillWe),
    .refillIdx  (refillIdx),
    .refillVpn  (refillVpn),
    .refillPpn  (refillPpn),
    .lookHit    (lookHit),
    .respPaddr  (respPaddr),
    .missVpn    (missVpn),
    .missIsData (missIsData),
    .pteAddr    (pteAddr)
  );

  assign instStall  = strb.instStall;
  assign respValid  = strb.lookValid;
  assign respIsData = strb.lookValid & strb.selData;
  assign respHit    = lookHit;
endmodule

// File: rtl/sw_tlb_chk.sv
module sw_tlb_chk
  import tlb_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             instReq,
  input logic [VA_W-1:0]  instVaddr,
  input logic             dataReq,
  input logic [VA_W-1:0]  dataVaddr,
  input logic             instStall,
  input logic             respValid,
  input logic             respIsData,
  input logic             respHit,
  input logic [PA_W-1:0]  respPaddr,
  input logic             trapReq,
  input logic [VPN_W-1:0] missVpn,
  input logic             refillWe
);
  logic [OFF_W-1:0] servedOff;
  assign servedOff = dataReq ? dataVaddr[OFF_W-1:0] : instVaddr[OFF_W-1:0];

  // R1
  hit_offset_chk: assert property (@(posedge clk) disable iff (!rstN)
    respHit |-> respPaddr[OFF_W-1:0] == servedOff);

  // R4
  data_prio_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instReq && dataReq) |-> (respIsData && instStall));

  // R5
  miss_trap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respHit && !trapReq && !refillWe) |=> trapReq);

  // R6
  trap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trapReq && !refillWe) |=> (trapReq && $stable(missVpn)));

  // R7
  refill_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    refillWe |=> !trapReq);

  // R11
  idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!instReq && !dataReq) |-> (!respValid && !respHit));
endmodule

bind sw_tlb sw_tlb_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .instReq    (instReq),
  .instVaddr  (instVaddr),
  .dataReq    (dataReq),
  .dataVaddr  (dataVaddr),
  .instStall  (instStall),
  .respValid  (respValid),
  .respIsData (respIsData),
  .respHit    (respHit),
  .respPaddr  (respPaddr),
  .trapReq    (trapReq),
  .missVpn    (missVpn),
  .refillWe   (refillWe)
);

// File: tb/sim_sw_tlb.sv
module sim_sw_tlb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instReq = 1'b0, dataReq = 1'b0;
  logic [31:0] instVaddr = '0, dataVaddr = '0;
  logic        instStall, respValid, respIsData, respHit;
  logic [31:0] respPaddr, pteAddr;
  logic        trapReq, missIsData;
  logic [19:0] missVpn;
  logic        ptBaseWe = 1'b0;
  logic [31:0] ptBaseData = '0;
  logic        refillWe = 1'b0;
  logic [3:0]  refillIdx = '0;
  logic [19:0] refillVpn = '0, refillPpn = '0;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  sw_tlb u0 (.*);

  function automatic logic [19:0] vpnOf(int i);
    return 20'h10000 + 20'(i) * 20'h123;
  endfunction
  function automatic logic [19:0] ppnOf(int i);
    return 20'h80000 + 20'(i) * 20'h0A5;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(bit iR, logic [31:0] iV, bit dR, logic [31:0] dV,
                       bit rW, logic [3:0] rI, logic [19:0] rV, logic [19:0] rP,
                       bit bW, logic [31:0] bD);
    @(negedge clk);
    instReq = iR; instVaddr = iV; dataReq = dR; dataVaddr = dV;
    refillWe = rW; refillIdx = rI; refillVpn = rV; refillPpn = rP;
    ptBaseWe = bW; ptBaseData = bD;
    #2;
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic refill(int idx, logic [19:0] v, logic [19:0] p);
    drive(0, 0, 0, 0, 1, 4'(idx), v, p, 0, 0);
    idle();
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        failures++;
        $display("FAIL watchdog actual=%h expected=%h", cycles, 100000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    logic [11:0] offs [4];
    logic [31:0] va;
    offs[0] = 12'h000; offs[1] = 12'h001; offs[2] = 12'h7FF; offs[3] = 12'hFFF;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idle();
    // R3 reset state
    chk(trapReq == 0, "R3 trap after reset", 32'(trapReq), 0);
    chk(missVpn == 0, "R3 missVpn after reset", 32'(missVpn), 0);
    // R11 no request
    chk(!respValid && !respHit, "R11 idle", 32'({respValid, respHit}), 0);

    // R3 lookup misses after reset; R5 capture from data port
    drive(0, 0, 1, 32'h12345678, 0, 0, 0, 0, 0, 0);
    chk(respHit == 0, "R3 miss after reset", 32'(respHit), 0);
    idle();
    chk(trapReq == 1, "R5 trap raised", 32'(trapReq), 1);
    chk(missVpn == 20'h12345, "R5 missVpn", 32'(missVpn), 32'h12345);
    chk(missIsData == 1, "R5 missIsData data", 32'(missIsData), 1);
    chk(pteAddr == 32'h12345 * 4, "R8 pte base 0", pteAddr, 32'h12345 * 4);

    // R8 base load while trap pending
    drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h0040_0000);
    idle();
    chk(pteAddr == 32'h0040_0000 + 32'h12345 * 4, "R8 pte with base",
        pteAddr, 32'h0040_0000 + 32'h12345 * 4);

    // R6 further miss while pending
    drive(1, 32'hCAFE0123, 0, 0, 0, 0, 0, 0, 0, 0);
    idle();
    chk(missVpn == 20'h12345, "R6 missVpn held", 32'(missVpn), 32'h12345);
    chk(missIsData == 1, "R6 missIsData held", 32'(missIsData), 1);
    chk(trapReq == 1, "R6 trap held", 32'(trapReq), 1);

    // R7 first refill clears the trap
    refill(0, vpnOf(0), ppnOf(0));
    chk(trapReq == 0, "R7 refill clears trap", 32'(trapReq), 0);
    for (int i = 1; i < 16; i++) refill(i, vpnOf(i), ppnOf(i));

    // R1 R2 sweep of slots, offsets and ports
    for (int i = 0; i < 16; i++) begin
      for (int o = 0; o < 4; o++) begin
        for (int p = 0; p < 2; p++) begin
          va = {vpnOf(i), offs[o]};
          if (p == 0) drive(1, va, 0, 0, 0, 0, 0, 0, 0, 0);
          else        drive(0, 0, 1, va, 0, 0, 0, 0, 0, 0);
          chk(respHit == 1, "R2 slot hit", 32'(respHit), 1);
          chk(respPaddr == {ppnOf(i), offs[o]}, "R1 paddr",
              respPaddr, {ppnOf(i), offs[o]});
        end
      end
    end
    idle();
    chk(trapReq == 0, "R2 no trap on hits", 32'(trapReq), 0);

    // R4 data priority
    drive(1, {vpnOf(3), 12'h111}, 1, {vpnOf(5), 12'h222}, 0, 0, 0, 0, 0, 0);
    chk(respIsData == 1 && instStall == 1, "R4 data wins",
        32'({respIsData, instStall}), 32'h3);
    chk(respPaddr == {ppnOf(5), 12'h222}, "R4 data paddr", respPaddr,
        {ppnOf(5), 12'h222});
    drive(1, {vpnOf(3), 12'h111}, 0, 0, 0, 0, 0, 0, 0, 0);
    chk(instStall == 0 && respIsData == 0, "R4 inst alone",
        32'({respIsData, instStall}), 0);
    chk(respPaddr == {ppnOf(3), 12'h111}, "R4 inst paddr", respPaddr,
        {ppnOf(3), 12'h111});

    // R9 duplicate tags
    refill(9, vpnOf(2), 20'hABCDE);
    drive(0, 0, 1, {vpnOf(2), 12'h010}, 0, 0, 0, 0, 0, 0);
    chk(respPaddr == {ppnOf(2), 12'h010}, "R9 lower slot wins", respPaddr,
        {ppnOf(2), 12'h010});
    refill(1, vpnOf(2), 20'h13579);
    drive(1, {vpnOf(2), 12'h020}, 0, 0, 0, 0, 0, 0, 0, 0);
    chk(respPaddr == {20'h13579, 12'h020}, "R9 new lowest slot", respPaddr,
        {20'h13579, 12'h020});

    // R7 miss in the same cycle as a refill is not captured
    drive(0, 0, 1, 32'hDEAD0004, 1, 4'd15, 20'hDEAD0, 20'h77777, 0, 0);
    idle();
    chk(trapReq == 0, "R7 same-cycle miss dropped", 32'(trapReq), 0);
    drive(0, 0, 1, 32'hDEAD0004, 0, 0, 0, 0, 0, 0);
    chk(respPaddr == 32'h77777004, "R7 refilled slot", respPaddr, 32'h77777004);

    // R5 instruction-side miss
    drive(1, 32'hCAFE0123, 0, 0, 0, 0, 0, 0, 0, 0);
    idle();
    chk(trapReq == 1 && missIsData == 0, "R5 inst miss",
        32'({trapReq, missIsData}), 32'h2);
    chk(missVpn == 20'hCAFE0, "R5 inst missVpn", 32'(missVpn), 32'hCAFE0);
    chk(pteAddr == 32'h0040_0000 + 32'hCAFE0 * 4, "R8 pte inst",
        pteAddr, 32'h0040_0000 + 32'hCAFE0 * 4);

    // R10 hit while trap pending
    drive(0, 0, 1, {vpnOf(7), 12'h456}, 0, 0, 0, 0, 0, 0);
    chk(respPaddr == {ppnOf(7), 12'h456}, "R10 hit during trap", respPaddr,
        {ppnOf(7), 12'h456});
    idle();
    chk(trapReq == 1 && missVpn == 20'hCAFE0, "R10 trap untouched",
        32'(missVpn), 32'hCAFE0);

    // R11 idle again
    chk(!respValid && !respHit && respPaddr == 0, "R11 idle output",
        respPaddr, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule